// File: doc/BRIEF.md
# Composite-Field GF(4096) Multiplier

This block multiplies two 12-bit elements of the finite field GF(4096). The field is not built from one degree-12 polynomial. It is a quadratic extension over GF(64), and GF(64) is reduced by x^6+x+1. Each operand is treated as a pair of 6-bit base-field digits. Three base-field products combine the digits, and a fourth scales one partial product by the fixed base-field constant 0x21. That constant is the extension polynomial's term A^-1.

A second mode turns the block into the successor function of a Reed-Solomon codec's power sequence. The first operand is multiplied by the fixed generator constant 0xE01, and a zero input is mapped to one. Repeated application starting from zero walks through the nonzero field elements. Table-building logic above this step belongs to the user.

A parameter chooses the output stage. With `OUT_REG` = 1 the product is registered, giving one cycle of latency with a valid flag alongside. With `OUT_REG` = 0 the product is combinational and the valid flag is a wire copy.

Top module: `gf4096_tower_mul`

## Requirements
- R1: In multiply mode (`step_mode`=0), with a = {ah,al} and b = {bh,bl} split into 6-bit halves (high half in bits 11:6), the result's high half is m(ah^al, bh^bl) ^ m(al,bl). The low half is m(m(ah,bh), 0x21) ^ m(al,bl), where m is GF(64) multiplication.
- R2: GF(64) multiplication is shift-and-add over six steps. Whenever the shifted operand overflows into bit 6, it is reduced by XOR with 0x43. For example, 0x020 times 0x002 gives 0x003.
- R3: In multiply mode, the result is 0 whenever either operand is 0.
- R4: In multiply mode, an operand equal to 0x001 returns the other operand unchanged.
- R5: Multiplication is commutative: swapping `op_a` and `op_b` gives the same result.
- R6: In step mode (`step_mode`=1), an `op_a` of 0 gives the result 0x001.
- R7: In step mode, a nonzero `op_a` gives `op_a` times 0xE01 under the R1 rule, and `op_b` has no effect.
- R8: With `OUT_REG`=1, `product` and `out_valid` show the inputs' result one clock after they are applied. Both are 0 while `rst_n` is low.
- R9: A product of nonzero factors is never 0. This covers multiply mode with both operands nonzero and step mode with any input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks the operands as meaningful |
| step_mode | input | 1 | 0 = multiply op_a by op_b; 1 = power-sequence step on op_a |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand, ignored in step mode |
| out_valid | output | 1 | Valid flag aligned with product |
| product | output | 12 | Field product or step result |

## Verification
The properties assume the operands and the mode select are held stable across each sampling edge. For the registered variant they also assume that each cycle's inputs describe exactly one operation. The stimulus satisfies this by changing every input only on the falling clock edge and presenting one operation per cycle. Random operand pairs use a fixed seed. Directed cases cover zero, one, the overflow-into-bit-6 pair and step mode with a random `op_b`. Expected results come from the bench's own bit-serial model of the tower rule.

// File: rtl/gf4096_pkg.sv
package gf4096_pkg;
    localparam int SUB_W  = 6;
    localparam int FULL_W = 2 * SUB_W;
    // low six bits of x^6+x+1 after the x^6 term is folded back
    localparam logic [SUB_W-1:0]  SUB_FOLD  = 6'h03;
    // constant term of the extension polynomial
    localparam logic [SUB_W-1:0]  EXT_CONST = 6'h21;
    // generator used by the power-sequence step
    localparam logic [FULL_W-1:0] STEP_GEN  = 12'hE01;
    localparam logic [FULL_W-1:0] FIELD_ONE = 12'h001;

    typedef logic [SUB_W-1:0]  sub_elem_t;
    typedef logic [FULL_W-1:0] elem_t;

    typedef enum logic [0:0] {
        OP_MUL  = 1'b0,
        OP_STEP = 1'b1
    } op_kind_e;
endpackage

// File: rtl/gf64_mul.sv
module gf64_mul
    import gf4096_pkg::*;
(
    input  logic [SUB_W-1:0] x,
    input  logic [SUB_W-1:0] y,
    output logic [SUB_W-1:0] z
);
    // y_sh[k] is y times alpha^k, acc[k] the partial sum after k bits of x
    logic [SUB_W-1:0] y_sh [SUB_W+1];
    logic [SUB_W-1:0] acc  [SUB_W+1];

    assign y_sh[0] = y;
    assign acc[0]  = '0;

    for (genvar k = 0; k < SUB_W; k++) begin : g_step
        assign acc[k+1]  = acc[k] ^ (x[k] ? y_sh[k] : '0);
        assign y_sh[k+1] = {y_sh[k][SUB_W-2:0], 1'b0}
                         ^ (y_sh[k][SUB_W-1] ? SUB_FOLD : '0);
    end

    assign z = acc[SUB_W];
endmodule

// File: rtl/gf4096_core.sv
module gf4096_core
    import gf4096_pkg::*;
(
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] b,
    output logic [FULL_W-1:0] p
);
    logic [SUB_W-1:0] a_hi, a_lo, b_hi, b_lo;
    logic [SUB_W-1:0] m_cross, m_low, m_high, m_scaled;

    assign a_hi = a[FULL_W-1:SUB_W];
    assign a_lo = a[SUB_W-1:0];
    assign b_hi = b[FULL_W-1:SUB_W];
    assign b_lo = b[SUB_W-1:0];

    gf64_mul u_cross (.x(a_hi ^ a_lo), .y(b_hi ^ b_lo), .z(m_cross));
    gf64_mul u_low   (.x(a_lo),        .y(b_lo),        .z(m_low));
    gf64_mul u_high  (.x(a_hi),        .y(b_hi),        .z(m_high));
    gf64_mul u_scale (.x(m_high),      .y(EXT_CONST),   .z(m_scaled));

    assign p = {m_cross ^ m_low, m_scaled ^ m_low};
endmodule

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul
    import gf4096_pkg::*;
#(
    parameter int OUT_REG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              step_mode,
    input  logic [11:0]       op_a,
    input  logic [11:0]       op_b,
    output logic              out_valid,
    output logic [11:0]       product
);
    op_kind_e          kind;
    logic [FULL_W-1:0] rhs;
    logic [FULL_W-1:0] core_p;
    logic [FULL_W-1:0] result;

    assign kind = op_kind_e'(step_mode);

    always_comb begin
        unique case (kind)
            OP_MUL:  rhs = op_b;
            OP_STEP: rhs = STEP_GEN;
            default: rhs = op_b;
        endcase
    end

    gf4096_core u_core (.a(op_a), .b(rhs), .p(core_p));

    always_comb begin
        if (kind == OP_STEP && op_a == '0) result = FIELD_ONE;
        else                               result = core_p;
    end

    if (OUT_REG != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                product   <= '0;
                out_valid <= 1'b0;
            end else begin
                product   <= result;
                out_valid <= in_valid;
            end
        end
    end else begin : g_comb
        assign product   = result;
        assign out_valid = in_valid;
    end
endmodule

// File: rtl/gf4096_tower_mul_chk.sv
module gf4096_tower_mul_chk #(
    parameter int OUT_REG = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        step_mode,
    input logic [11:0] op_a,
    input logic [11:0] op_b,
    input logic        out_valid,
    input logic [11:0] product
);
    if (OUT_REG != 0) begin : g_seq
        p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!step_mode && (op_a == 12'h0 || op_b == 12'h0)) |=> product == 12'h0);
        p_ident_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!step_mode && op_b == 12'h001) |=> product == $past(op_a));
        p_step_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (step_mode && op_a == 12'h0) |=> product == 12'h001);
        p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> out_valid == $past(in_valid));
        p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (op_a != 12'h0 && (step_mode || op_b != 12'h0)) |=> product != 12'h0);
    end else begin : g_cmb
        always_comb begin
            if (rst_n) begin
                if (!step_mode && (op_a == 12'h0 || op_b == 12'h0))
                    p_zero_r3: assert (product == 12'h0);
                if (step_mode && op_a == 12'h0)
                    p_step_zero_r6: assert (product == 12'h001);
                p_latency_r8: assert (out_valid == in_valid);
            end
        end
    end
endmodule

bind gf4096_tower_mul gf4096_tower_mul_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .step_mode(step_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
);

// File: tb/gf4096_tower_mul_bench.sv
`timescale 1ns/1ps
module gf4096_tower_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        step_mode = 1'b0;
    logic [11:0] op_a = '0;
    logic [11:0] op_b = '0;
    logic        out_valid;
    logic [11:0] product;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gf4096_tower_mul #(.OUT_REG(1)) u_gf4096_tower_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .step_mode(step_mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
    );

    function automatic logic [5:0] ref64(input logic [5:0] x, input logic [5:0] y);
        logic [6:0] t;
        logic [5:0] r;
        t = {1'b0, y};
        r = '0;
        for (int i = 0; i < 6; i++) begin
            if (x[i]) r ^= t[5:0];
            t = t << 1;
            if (t[6]) t ^= 7'h43;
        end
        return r;
    endfunction

    function automatic logic [11:0] ref4k(input logic [11:0] a, input logic [11:0] b);
        logic [5:0] hi, lo;
        lo = ref64(ref64(a[11:6], b[11:6]), 6'h21) ^ ref64(a[5:0], b[5:0]);
        hi = ref64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ ref64(a[5:0], b[5:0]);
        return {hi, lo};
    endfunction

    function automatic logic [11:0] refstep(input logic [11:0] a);
        return (a == 12'h0) ? 12'h001 : ref4k(a, 12'hE01);
    endfunction

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %03h expected %03h", req, got, exp);
        end
    endtask

    // apply at falling edge, result registered at next rising edge, sample at next falling edge
    task automatic run(input logic sm, input logic [11:0] a, input logic [11:0] b,
                       output logic [11:0] res);
        step_mode = sm; op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        res = product;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] r1, r2;
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        check("R8 reset product", product, 12'h0);
        check("R8 reset valid", {11'h0, out_valid}, 12'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: valid follows in one cycle
        run(1'b0, 12'h123, 12'h456, r1);
        check("R8 valid high", {11'h0, out_valid}, 12'h1);
        check("R1 directed", r1, ref4k(12'h123, 12'h456));
        in_valid = 1'b0;
        @(negedge clk);
        check("R8 valid low", {11'h0, out_valid}, 12'h0);

        // R2: base field overflow
        run(1'b0, 12'h020, 12'h002, r1);
        check("R2 overflow fold", r1, 12'h003);
        for (int i = 0; i < 20; i++) begin
            logic [5:0] x, y;
            x = 6'($urandom); y = 6'($urandom);
            run(1'b0, {6'h0, x}, {6'h0, y}, r1);
            check("R2 low-half product", r1, {6'h0, ref64(x, y)});
        end

        // R3 / R4
        run(1'b0, 12'h000, 12'hABC, r1);
        check("R3 zero a", r1, 12'h0);
        run(1'b0, 12'hFFF, 12'h000, r1);
        check("R3 zero b", r1, 12'h0);
        run(1'b0, 12'h001, 12'h9A7, r1);
        check("R4 one a", r1, 12'h9A7);
        run(1'b0, 12'hFFF, 12'h001, r1);
        check("R4 one b", r1, 12'hFFF);

        // R6 / R7
        run(1'b1, 12'h000, 12'h5A5, r1);
        check("R6 step zero", r1, 12'h001);
        run(1'b1, 12'h001, 12'h000, r1);
        check("R7 step one", r1, 12'hE01);
        for (int i = 0; i < 40; i++) begin
            logic [11:0] a, b;
            a = 12'($urandom); b = 12'($urandom);
            run(1'b1, a, b, r1);
            check("R7 step random", r1, refstep(a));
            if (a != 12'h0) check("R9 step nonzero", {11'h0, (r1 != 12'h0)}, 12'h1);
        end

        // R1 / R5 / R9 random
        for (int i = 0; i < 300; i++) begin
            logic [11:0] a, b;
            a = 12'($urandom); b = 12'($urandom);
            run(1'b0, a, b, r1);
            check("R1 random", r1, ref4k(a, b));
            run(1'b0, b, a, r2);
            check("R5 commutative", r2, r1);
            if (a != 12'h0 && b != 12'h0)
                check("R9 nonzero", {11'h0, (r1 != 12'h0)}, 12'h1);
        end

        in_valid = 1'b0;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule